// File: doc/BRIEF.md
# Byte-Mode Control Register Target for a Quad Clock-Output Controller

This block is a two-wire serial target that lets a bus controller read and write a small bank of control registers for a clock generator with four outputs. The bus lines are brought into the system clock domain by two-flop synchronizers. START and STOP are found there as SDA edges while SCL is high. The target pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit.

Every transfer first sends a command byte. The top six bits of that byte must equal `100000` to select single-byte mode. The low two bits give the register offset. A write sends the address with R/W=0, then the command byte, then one data byte. A read sends the address with R/W=0 and the command byte, then a repeated START, the address with R/W=1, one byte from the target, and a NACK from the controller. Only offset 0 has a register behind it. Its bits 6..3 drive the enables of clock outputs 3..0.

Top module: `clkgen_i2c_regs`

## Requirements
- R1: After reset `out_en` is 4'b1111 and `sda_oe` is 0 (SDA released).
- R2: A write with a matching address, command 0x80 and data D is acknowledged on the address, command and data bytes. After the transfer, `out_en[k]` equals D[3+k] for k = 0..3, so bit 6 controls output 3 and bit 3 controls output 0.
- R3: A read of offset 0 (command 0x80, then a repeated START, then a read address) returns the register byte MSB first. Bits 6..3 hold the current enables, and bits 7 and 2..0 always read 0 whatever was written to them.
- R4: A command byte whose bits 7..2 are not `100000` is still acknowledged. The data byte that follows is acknowledged too, but it changes no register and no output, and a read under such a command returns 0x00.
- R5: Offsets 1, 2 and 3 (commands 0x81..0x83) read as 0x00, and writes to them leave `out_en` unchanged.
- R6: An address byte that differs from `dev_addr` gets no acknowledge. SDA stays released for the rest of that transfer and nothing changes until the next START.
- R7: `sda_oe` changes only while SCL is low, except for a release at START or STOP. It is released after the final read bit, so the controller's NACK is seen on the bus.
- R8: A START in the middle of a transfer abandons it and restarts address reception, so a complete write that follows takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Configured 7-bit target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| out_en | output | 4 | Per-output enables, bit k for clock output k |

## Verification
Writes use data patterns that set alternate enables, all ones (reserved bits included), and all zeros. A swapped or shifted bit field then shows up as a wrong enable on a particular output, and reserved bits that leak show up on readback. Command bytes 0x00, 0xC0 and 0x82 are sent with data that would otherwise change the outputs. A wrong address, a START cut into a command byte, and reads of each unused offset cover the ignore paths. A reference model in the bench tracks the expected enables and compares them on every clock. A second monitor flags any change of SDA drive while SCL is high.

// File: rtl/clkgen_i2c_pkg.sv
package clkgen_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 2;
  localparam logic [5:0] BYTE_MODE_TAG = 6'b100000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK,
    ST_WR, ST_WACK, ST_RD, ST_RACK, ST_IGNORE
  } tgt_state_t;

  function automatic logic cmd_is_byte(input logic [BYTE_W-1:0] cmd);
    return cmd[BYTE_W-1:OFF_W] == BYTE_MODE_TAG;
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_target.sv
module i2c_byte_target
  import clkgen_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        dev_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [OFF_W-1:0]  reg_off,
  output logic              reg_ok,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  tgt_state_t        st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg, txsh, cmd_q;
  logic              rw;
  logic              byte_done;

  assign byte_done = scl_fall && (cnt == 4'd8);
  assign reg_off   = cmd_q[OFF_W-1:0];
  assign reg_ok    = cmd_is_byte(cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; shreg <= '0; txsh <= '0; cmd_q <= '0;
      rw <= 1'b0; wr_stb <= 1'b0; wr_data <= '0; sda_oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_done) begin
              if (st == ST_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  st <= ST_AACK; sda_oe <= 1'b1; rw <= shreg[0];
                end else begin
                  st <= ST_IGNORE;
                end
              end else if (st == ST_CMD) begin
                cmd_q <= shreg; st <= ST_CACK; sda_oe <= 1'b1;
              end else begin
                wr_stb <= reg_ok; wr_data <= shreg;
                st <= ST_WACK; sda_oe <= 1'b1;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              txsh <= rd_data; sda_oe <= ~rd_data[BYTE_W-1]; st <= ST_RD;
            end else begin
              sda_oe <= 1'b0; st <= ST_CMD;
            end
          end
          ST_CACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; st <= ST_WR;
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= ST_IGNORE;
          end
          ST_RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (byte_done) begin
              sda_oe <= 1'b0; st <= ST_RACK;
            end else if (scl_fall) begin
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txsh[BYTE_W-2];
            end
          end
          ST_RACK: if (scl_rise) st <= ST_IGNORE;
          default: ;
        endcase
      end
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(start_evt) || $past(stop_evt))); // R7
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> !sda_oe); // R7
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe); // R6
endmodule

// File: rtl/clkgen_ctl_bank.sv
module clkgen_ctl_bank
  import clkgen_i2c_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int OE_LSB  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [OFF_W-1:0]   reg_off,
  input  logic               reg_ok,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [NUM_OUT-1:0] out_en
);
  localparam int OE_MSB = OE_LSB + NUM_OUT - 1;

  logic [NUM_OUT-1:0] oe_q;

  function automatic logic [BYTE_W-1:0] pack_byte0(input logic [NUM_OUT-1:0] oe);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[OE_MSB:OE_LSB] = oe;
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= '1;
    else if (wr_stb && reg_off == '0) oe_q <= wr_data[OE_MSB:OE_LSB];
  end

  assign rd_data = (reg_ok && reg_off == '0) ? pack_byte0(oe_q) : '0;
  assign out_en  = oe_q;
endmodule

// File: rtl/clkgen_i2c_regs.sv
module clkgen_i2c_regs
  import clkgen_i2c_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int OE_LSB      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [6:0]         dev_addr,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NUM_OUT-1:0] out_en
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic [OFF_W-1:0]  reg_off;
  logic reg_ok, wr_stb;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2c_byte_target u_tgt (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data),
    .reg_off(reg_off), .reg_ok(reg_ok), .wr_stb(wr_stb), .wr_data(wr_data),
    .sda_oe(sda_oe));

  clkgen_ctl_bank #(.NUM_OUT(NUM_OUT), .OE_LSB(OE_LSB)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .reg_off(reg_off), .reg_ok(reg_ok), .rd_data(rd_data), .out_en(out_en));

  AST_OE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_en) |-> $past(wr_stb)); // R4
endmodule

// File: tb/clkgen_i2c_regs_bench.sv
module clkgen_i2c_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] ADDR = 7'h6C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [3:0] out_en;
  int errors = 0, checks = 0, mon_bad = 0, sda_bad = 0;
  logic [3:0] ref_oe = 4'b1111;
  bit hold = 1'b0, done = 1'b0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkgen_i2c_regs u_clkgen_i2c_regs (
    .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .scl_i(scl_drv),
    .sda_i(sda_line), .sda_oe(sda_oe), .out_en(out_en));

  always @(negedge clk) begin
    if (rst_n) begin
      if (!hold && out_en !== ref_oe) mon_bad++;
      if (sda_oe !== prev_oe && scl_drv && prev_scl) sda_bad++;
    end
    prev_oe  = sda_oe;
    prev_scl = scl_drv;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF); scl_drv = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF); scl_drv = 1'b0; wt(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF); scl_drv = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(HALF); scl_drv = 1'b1; wt(HALF); scl_drv = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(HALF); scl_drv = 1'b1; wt(HALF/2);
    ack = !sda_line; wt(HALF/2); scl_drv = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF); scl_drv = 1'b1; wt(HALF/2); b[i] = sda_line;
      wt(HALF/2); scl_drv = 1'b0;
    end
    send_bit(1'b1); // controller NACK
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd,
                          input logic [7:0] d, output bit ka, output bit kc, output bit kd);
    bus_start();
    send_byte({a, 1'b0}, ka);
    send_byte(cmd, kc);
    hold = 1'b1;
    send_byte(d, kd);
    bus_stop();
    if (a == ADDR && cmd[7:2] == 6'b100000 && cmd[1:0] == 2'd0) ref_oe = d[6:3];
    hold = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] cmd, output logic [7:0] d, output bit rel);
    bit k;
    bus_start();
    send_byte({ADDR, 1'b0}, k);
    send_byte(cmd, k);
    sda_m = 1'b1; wt(HALF); scl_drv = 1'b1; wt(HALF); sda_m = 1'b0; wt(HALF);
    scl_drv = 1'b0; wt(HALF/2);
    send_byte({ADDR, 1'b1}, k);
    recv_byte(d);
    wt(2);
    rel = !sda_oe;
    bus_stop();
  endtask

  initial begin
    bit ka, kc, kd, rel;
    logic [7:0] d;
    wt(5);
    rst_n = 1'b1;
    wt(4);
    chk(out_en == 4'b1111, "R1 out_en after reset", out_en, 4'hF);
    chk(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);

    do_read(8'h80, d, rel);
    chk(d == 8'h78, "R3 read power-up byte", d, 8'h78);
    chk(rel, "R7 release after final read bit", !rel, 0);

    do_write(ADDR, 8'h80, 8'h28, ka, kc, kd);
    chk(ka && kc && kd, "R2 acks on write", {ka, kc, kd}, 7);
    chk(out_en == 4'b0101, "R2 enables from 0x28", out_en, 4'h5);
    do_read(8'h80, d, rel);
    chk(d == 8'h28, "R3 readback 0x28", d, 8'h28);

    do_write(ADDR, 8'h80, 8'hFF, ka, kc, kd);
    chk(out_en == 4'b1111, "R2 enables from 0xFF", out_en, 4'hF);
    do_read(8'h80, d, rel);
    chk(d == 8'h78, "R3 reserved bits read 0", d, 8'h78);

    do_write(ADDR, 8'h80, 8'h50, ka, kc, kd);
    chk(out_en == 4'b1010, "R2 enables from 0x50", out_en, 4'hA);

    do_write(ADDR, 8'h00, 8'h00, ka, kc, kd);
    chk(ka && kc && kd, "R4 bad command still acked", {ka, kc, kd}, 7);
    chk(out_en == 4'b1010, "R4 data ignored cmd 0x00", out_en, 4'hA);
    do_write(ADDR, 8'hC0, 8'h78, ka, kc, kd);
    chk(out_en == 4'b1010, "R4 data ignored cmd 0xC0", out_en, 4'hA);
    do_read(8'h40, d, rel);
    chk(d == 8'h00, "R4 read under bad command", d, 0);

    do_write(ADDR, 8'h82, 8'h00, ka, kc, kd);
    chk(out_en == 4'b1010, "R5 write to offset 2 ignored", out_en, 4'hA);
    for (int o = 1; o < 4; o++) begin
      do_read(8'h80 | 8'(o), d, rel);
      chk(d == 8'h00, "R5 unused offset reads 0", d, 0);
    end

    do_write(ADDR ^ 7'h01, 8'h80, 8'h00, ka, kc, kd);
    chk(!ka && !kc && !kd, "R6 no ack on wrong address", {ka, kc, kd}, 0);
    chk(out_en == 4'b1010, "R6 no change on wrong address", out_en, 4'hA);

    bus_start();
    send_byte({ADDR, 1'b0}, ka);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    do_write(ADDR, 8'h80, 8'h00, ka, kc, kd);
    chk(ka && kc && kd, "R8 acks after restart", {ka, kc, kd}, 7);
    chk(out_en == 4'b0000, "R8 write after mid-byte START", out_en, 0);

    chk(mon_bad == 0, "R2 per-clock model compare", mon_bad, 0);
    chk(sda_bad == 0, "R7 sda drive steady while SCL high", sda_bad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule